// File: doc/BRIEF.md
# Closed-Loop Frequency Tuner for a Frequency-Locked Loop

This block is the digital control loop of a frequency-locked oscillator. Once per reference-clock period an upstream counter delivers the number of output-clock cycles seen in that period. The tuner compares that count with a programmed multiplier, which is also the target count, and moves two oscillator control codes toward the target. A wide coarse code is tuned first. Once it has settled, a narrow fine code is tuned. Each move is limited by a programmable maximum step for its code.

Software sets the block up through a simple register write port. It loads the multiplier, the two step limits and, if it wishes, starting codes. It then sets the mode bit to close the loop. While the loop is closed the tuner alone drives the codes. After both lock flags are set, software can read the codes and clear the mode bit, and the codes then stay frozen in open loop.

Top module: `dfll_tuner`

## Requirements
- R1: After reset the mode is open loop, the multiplier is 0, both step limits are 1, the coarse code is 0, the fine code is 127 (half of full scale, 255 >> 1) and both lock flags are 0.
- R2: The write port has six fields, chosen by `wr_sel`: 0 is the mode (bit 0), 1 the multiplier, 2 the coarse step, 3 the fine step, 4 the coarse code, 5 the fine code. In open loop, code writes take effect and reference strobes leave both codes unchanged.
- R3: In closed loop, writes to the coarse or fine code field leave the codes unchanged.
- R4: On a 0-to-1 write of the mode bit, the coarse code keeps its present value.
- R5: On a 0-to-1 mode write, the fine code becomes 127 unless a fine code was written after the most recent multiplier write. A fine write made before that multiplier write is discarded.
- R6: A fine code written after the most recent multiplier write is kept as the fine starting value when the loop closes.
- R7: In the coarse stage, each strobe takes err = multiplier − count. If |err| > 16 and the step direction has not reversed, the coarse code moves toward a higher count when err > 0 and toward a lower count when err < 0, by min(|err| >> 4, coarse limit). A limit of 0 acts as 1. The codes change only on a strobe.
- R8: A coarse step write above 15 is stored as 15. A fine step write above 127 is stored as 127.
- R9: Both codes saturate at 0 and at full scale (coarse 31, fine 255).
- R10: In the coarse stage, a strobe with |err| ≤ 16, or whose step direction is opposite to the previous coarse step, sets the coarse lock flag. It does not change the coarse code, and the fine stage starts.
- R11: In the fine stage, each strobe with err ≠ 0 moves the fine code by min(|err|, fine limit), which is at least 1. A strobe with err = 0 leaves the fine code unchanged. The fine lock flag sets after two consecutive strobes with |err| ≤ 1 and stays set.
- R12: A multiplier write, or a write of 0 to the mode bit, clears both lock flags. A multiplier write also restarts the coarse stage. If such a write falls in the same cycle as a strobe, the code update is computed from the settings held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tuner clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Field select for the write |
| wr_data | input | 16 | Write data |
| ref_tick | input | 1 | One-cycle strobe at the end of each reference period |
| out_count | input | 16 | Output-cycle count for the period just ended, valid with `ref_tick` |
| coarse_o | output | 5 | Coarse oscillator code |
| fine_o | output | 8 | Fine oscillator code |
| coarse_lock_o | output | 1 | Coarse stage settled |
| fine_lock_o | output | 1 | Fine stage settled |

## Verification
Two functions can fall in the same cycle: a register write (multiplier, mode, step limit) and a reference strobe that updates the codes. The bench provokes this by asserting a multiplier write in the very cycle of a strobe. It then judges that the coarse code moved by the amount the old multiplier implies, while both lock flags read zero and the coarse stage restarted. The sweeps of count error in both stages are compared against step sizes the bench derives arithmetically from the error, the limit and the saturation bounds.

// File: rtl/dfll_pkg.sv
package dfll_pkg;

    // Write-port field selectors
    typedef enum logic [2:0] {
        FLD_MODE   = 3'd0,
        FLD_MULT   = 3'd1,
        FLD_CSTEP  = 3'd2,
        FLD_FSTEP  = 3'd3,
        FLD_COARSE = 3'd4,
        FLD_FINE   = 3'd5
    } fld_e;

    localparam int unsigned DEF_CW     = 5;
    localparam int unsigned DEF_FW     = 8;
    localparam int unsigned DEF_MW     = 16;
    localparam int unsigned DEF_CSHIFT = 4;

endpackage

// File: rtl/dfll_err.sv
// Absolute count error and its direction.
module dfll_err #(
    parameter int unsigned MW = 16
) (
    input  logic [MW-1:0] target,
    input  logic [MW-1:0] count,
    output logic [MW-1:0] mag,
    output logic          up
);
    always_comb begin
        up  = target > count;
        mag = up ? (target - count) : (count - target);
    end
endmodule

// File: rtl/dfll_step.sv
// One saturating, limited, proportional code step.
module dfll_step #(
    parameter int unsigned W     = 5,
    parameter int unsigned MW    = 16,
    parameter int unsigned SHIFT = 4
) (
    input  logic [W-1:0]  code,
    input  logic [MW-1:0] mag,
    input  logic [W-1:0]  limit,
    input  logic          up,
    output logic [W-1:0]  nxt
);
    logic [MW-1:0] scaled;
    logic [W-1:0]  lim;
    logic [W-1:0]  stp;
    logic [W:0]    sum;

    always_comb begin
        scaled = mag >> SHIFT;
        lim    = (limit == '0) ? W'(1) : limit;
        if (scaled > MW'(lim))      stp = lim;
        else if (scaled == '0)      stp = W'(1);
        else                        stp = scaled[W-1:0];
        sum = {1'b0, code} + {1'b0, stp};
        if (up) nxt = sum[W] ? '1 : sum[W-1:0];
        else    nxt = (stp > code) ? '0 : (code - stp);
    end
endmodule

// File: rtl/dfll_tuner.sv
module dfll_tuner
    import dfll_pkg::*;
#(
    parameter int unsigned CW     = DEF_CW,
    parameter int unsigned FW     = DEF_FW,
    parameter int unsigned MW     = DEF_MW,
    parameter int unsigned CSHIFT = DEF_CSHIFT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [2:0]    wr_sel,
    input  logic [MW-1:0] wr_data,
    input  logic          ref_tick,
    input  logic [MW-1:0] out_count,
    output logic [CW-1:0] coarse_o,
    output logic [FW-1:0] fine_o,
    output logic          coarse_lock_o,
    output logic          fine_lock_o
);
    localparam logic [CW-1:0] CHALF = CW'(((1 << CW) - 1) >> 1);
    localparam logic [FW-1:0] FHALF = FW'(((1 << FW) - 1) >> 1);
    localparam logic [MW-1:0] CWIN  = MW'(1 << CSHIFT);

    typedef struct packed {
        logic          mode;
        logic [MW-1:0] mult;
        logic [CW-1:0] cstep;
        logic [FW-1:0] fstep;
        logic [CW-1:0] coarse;
        logic [FW-1:0] fine;
        logic          fine_pend;
        logic          in_fine;
        logic          dir_valid;
        logic          dir_up;
        logic          clock;
        logic          flock;
        logic [1:0]    fcnt;
    } st_t;

    st_t st_d, st_q;

    logic [MW-1:0] err_mag;
    logic          err_up;
    logic [CW-1:0] coarse_step;
    logic [FW-1:0] fine_step;

    dfll_err #(.MW(MW)) u_err (
        .target (st_q.mult),
        .count  (out_count),
        .mag    (err_mag),
        .up     (err_up)
    );

    dfll_step #(.W(CW), .MW(MW), .SHIFT(CSHIFT)) u_cstep (
        .code  (st_q.coarse),
        .mag   (err_mag),
        .limit (st_q.cstep),
        .up    (err_up),
        .nxt   (coarse_step)
    );

    dfll_step #(.W(FW), .MW(MW), .SHIFT(0)) u_fstep (
        .code  (st_q.fine),
        .mag   (err_mag),
        .limit (st_q.fstep),
        .up    (err_up),
        .nxt   (fine_step)
    );

    always_comb begin
        st_d = st_q;

        // Loop update, evaluated on the state held before this edge
        if (st_q.mode && ref_tick) begin
            if (!st_q.in_fine) begin
                if (err_mag <= CWIN ||
                    (st_q.dir_valid && (st_q.dir_up != err_up))) begin
                    st_d.clock   = 1'b1;
                    st_d.in_fine = 1'b1;
                    st_d.fcnt    = 2'd0;
                end else begin
                    st_d.coarse    = coarse_step;
                    st_d.dir_valid = 1'b1;
                    st_d.dir_up    = err_up;
                end
            end else begin
                if (err_mag != '0)
                    st_d.fine = fine_step;
                if (err_mag <= MW'(1)) begin
                    if (st_q.fcnt != 2'd2)
                        st_d.fcnt = st_q.fcnt + 2'd1;
                    if (st_q.fcnt >= 2'd1)
                        st_d.flock = 1'b1;
                end else begin
                    st_d.fcnt = 2'd0;
                end
            end
        end

        // Register writes, applied on top of the loop update
        if (wr_en) begin
            unique case (wr_sel)
                FLD_MODE: begin
                    st_d.mode = wr_data[0];
                    if (wr_data[0] && !st_q.mode) begin
                        st_d.fine      = st_q.fine_pend ? st_q.fine : FHALF;
                        st_d.in_fine   = 1'b0;
                        st_d.dir_valid = 1'b0;
                        st_d.fcnt      = 2'd0;
                        st_d.clock     = 1'b0;
                        st_d.flock     = 1'b0;
                    end
                    if (!wr_data[0]) begin
                        st_d.clock = 1'b0;
                        st_d.flock = 1'b0;
                    end
                end
                FLD_MULT: begin
                    st_d.mult      = wr_data;
                    st_d.fine_pend = 1'b0;
                    st_d.in_fine   = 1'b0;
                    st_d.dir_valid = 1'b0;
                    st_d.fcnt      = 2'd0;
                    st_d.clock     = 1'b0;
                    st_d.flock     = 1'b0;
                end
                FLD_CSTEP:
                    st_d.cstep = (wr_data > MW'(CHALF)) ? CHALF : wr_data[CW-1:0];
                FLD_FSTEP:
                    st_d.fstep = (wr_data > MW'(FHALF)) ? FHALF : wr_data[FW-1:0];
                FLD_COARSE:
                    if (!st_q.mode) st_d.coarse = wr_data[CW-1:0];
                FLD_FINE:
                    if (!st_q.mode) begin
                        st_d.fine      = wr_data[FW-1:0];
                        st_d.fine_pend = 1'b1;
                    end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q           <= '0;
            st_q.cstep     <= CW'(1);
            st_q.fstep     <= FW'(1);
            st_q.fine      <= FHALF;
        end else begin
            st_q <= st_d;
        end
    end

    assign coarse_o      = st_q.coarse;
    assign fine_o        = st_q.fine;
    assign coarse_lock_o = st_q.clock;
    assign fine_lock_o   = st_q.flock;

endmodule

// File: rtl/dfll_tuner_chk.sv
module dfll_tuner_chk #(
    parameter int unsigned CW = 5,
    parameter int unsigned FW = 8,
    parameter int unsigned MW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mode,
    input logic          wr_en,
    input logic [2:0]    wr_sel,
    input logic          ref_tick,
    input logic [CW-1:0] coarse_o,
    input logic [FW-1:0] fine_o,
    input logic          coarse_lock_o,
    input logic          fine_lock_o
);
    localparam int CHALF = ((1 << CW) - 1) >> 1;

    assert_open_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode && !(wr_en && wr_sel == 3'd4)) |=> $stable(coarse_o));

    assert_closed_ignore_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode && wr_en && wr_sel == 3'd4 && !ref_tick) |=> $stable(coarse_o));

    assert_tick_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ref_tick && !wr_en) |=> ($stable(coarse_o) && $stable(fine_o)));

    assert_coarse_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode && ref_tick && !wr_en) |=>
        ((int'(coarse_o) - int'($past(coarse_o)) <= CHALF) &&
         (int'($past(coarse_o)) - int'(coarse_o) <= CHALF)));

    assert_fine_after_coarse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fine_lock_o |-> coarse_lock_o);

    assert_lock_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 3'd1) |=> (!coarse_lock_o && !fine_lock_o));

endmodule

bind dfll_tuner dfll_tuner_chk #(.CW(CW), .FW(FW), .MW(MW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .mode          (st_q.mode),
    .wr_en         (wr_en),
    .wr_sel        (wr_sel),
    .ref_tick      (ref_tick),
    .coarse_o      (coarse_o),
    .fine_o        (fine_o),
    .coarse_lock_o (coarse_lock_o),
    .fine_lock_o   (fine_lock_o)
);

// File: tb/sim_dfll_tuner.sv
module sim_dfll_tuner;
    localparam int CLK_PERIOD = 10;
    localparam int M = 1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic        ref_tick = 1'b0;
    logic [15:0] out_count = '0;
    logic [4:0]  coarse_o;
    logic [7:0]  fine_o;
    logic        coarse_lock_o;
    logic        fine_lock_o;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dfll_tuner u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .ref_tick(ref_tick), .out_count(out_count),
        .coarse_o(coarse_o), .fine_o(fine_o),
        .coarse_lock_o(coarse_lock_o), .fine_lock_o(fine_lock_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int sel, input int data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 3'(sel); wr_data = 16'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic tick(input int cnt);
        @(negedge clk);
        ref_tick = 1'b1; out_count = 16'(cnt);
        @(negedge clk);
        ref_tick = 1'b0;
    endtask

    // open loop, load coarse (and fine if fv >= 0), then multiplier, then close
    task automatic setup(input int c, input int fv_before, input int fv_after);
        wr(0, 0);
        wr(4, c);
        if (fv_before >= 0) wr(5, fv_before);
        wr(1, M);
        if (fv_after >= 0) wr(5, fv_after);
        wr(0, 1);
    endtask

    function automatic int sat(input int v, input int mx);
        return (v < 0) ? 0 : ((v > mx) ? mx : v);
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int ef, cnt, flk;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 coarse", coarse_o, 0);
        chk("R1 fine", fine_o, 127);
        chk("R1 clock", coarse_lock_o, 0);
        chk("R1 flock", fine_lock_o, 0);

        // R2 open loop writes and ignored strobes
        wr(4, 10); wr(5, 50);
        chk("R2 coarse write", coarse_o, 10);
        chk("R2 fine write", fine_o, 50);
        tick(0);
        chk("R2 tick ignored coarse", coarse_o, 10);
        chk("R2 tick ignored fine", fine_o, 50);

        wr(2, 4); wr(3, 5);

        // R5 fine written before multiplier is discarded; R4 coarse kept
        setup(12, 50, -1);
        chk("R4 coarse start", coarse_o, 12);
        chk("R5 fine half", fine_o, 127);
        // R3 writes ignored in closed loop
        wr(4, 3); wr(5, 9);
        chk("R3 coarse ignored", coarse_o, 12);
        chk("R3 fine ignored", fine_o, 127);
        // R6 fine written after multiplier
        setup(12, -1, 60);
        chk("R6 fine start", fine_o, 60);

        // R7/R10 coarse sweep, cstep 4, start 16
        for (int e = -300; e <= 300; e += 10) begin
            int ae, st, exp_c;
            setup(16, -1, -1);
            tick(M - e);
            ae = (e < 0) ? -e : e;
            if (ae <= 16) begin
                exp_c = 16;
                chk("R10 lock in window", coarse_lock_o, 1);
            end else begin
                st = ae >> 4; if (st > 4) st = 4;
                exp_c = sat(16 + ((e > 0) ? st : -st), 31);
                chk("R7 no lock outside window", coarse_lock_o, 0);
            end
            chk("R7 coarse step", coarse_o, exp_c);
        end

        // R7 no update without a strobe
        setup(16, -1, -1);
        @(negedge clk); out_count = 16'(M + 500);
        repeat (3) @(negedge clk);
        chk("R7 no strobe no change", coarse_o, 16);

        // R10 reversal lock
        tick(M - 100);
        chk("R10 first step", coarse_o, 20);
        tick(M + 100);
        chk("R10 reversal holds coarse", coarse_o, 20);
        chk("R10 reversal lock", coarse_lock_o, 1);

        // R11 fine sweep with fstep 5
        setup(16, -1, -1);
        tick(M);
        chk("R10 zero err lock", coarse_lock_o, 1);
        ef = 127; cnt = 0; flk = 0;
        for (int e = -12; e <= 12; e++) begin
            int ae, st;
            tick(M - e);
            ae = (e < 0) ? -e : e;
            if (ae != 0) begin
                st = (ae > 5) ? 5 : ae;
                ef = sat(ef + ((e > 0) ? st : -st), 255);
            end
            if (ae <= 1) begin
                cnt = (cnt < 2) ? cnt + 1 : 2;
                if (cnt == 2) flk = 1;
            end else cnt = 0;
            chk("R11 fine step", fine_o, ef);
            chk("R11 fine lock", fine_lock_o, flk);
        end
        chk("R11 fine lock set", fine_lock_o, 1);

        // R12 mode clear drops locks, codes held
        wr(0, 0);
        chk("R12 mode clear clock", coarse_lock_o, 0);
        chk("R12 mode clear flock", fine_lock_o, 0);
        chk("R2 fine held", fine_o, ef);

        // R8/R9 step saturation and code saturation
        wr(3, 200);
        setup(16, -1, 60);
        tick(M);
        tick(M - 300);
        chk("R8 fine step capped 127", fine_o, 187);
        tick(M - 300);
        chk("R9 fine top", fine_o, 255);
        wr(2, 31);
        setup(0, -1, -1);
        tick(M - 1000);
        chk("R8 coarse step capped 15", coarse_o, 15);
        tick(M - 1000);
        tick(M - 1000);
        chk("R9 coarse top", coarse_o, 31);
        wr(2, 4);
        setup(1, -1, -1);
        tick(M + 500);
        chk("R9 coarse bottom", coarse_o, 0);
        setup(1, -1, -1);
        tick(M);
        wr(3, 5);
        tick(M + 900);
        chk("R9 fine start", fine_o, 122);

        // R12 multiplier write in the same cycle as a strobe
        setup(16, -1, -1);
        tick(M);
        chk("R12 pre lock", coarse_lock_o, 1);
        @(negedge clk);
        ref_tick = 1'b1; out_count = 16'(M);
        wr_en = 1'b1; wr_sel = 3'd1; wr_data = 16'(M + 200);
        @(negedge clk);
        ref_tick = 1'b0; wr_en = 1'b0;
        chk("R12 collide lock cleared", coarse_lock_o, 0);
        chk("R12 collide coarse held", coarse_o, 16);
        tick(M);
        chk("R12 restarted coarse stage", coarse_o, 20);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule